// File: doc/BRIEF.md
# Lockstep Execution Controller with Loop Detection

This block sits beside a co-simulation of two processors: a reference model and a core under test. Both report every retired instruction. The block decides when the shared run has to end, and it records why.

There are three reasons to end a run:
- The reference returns to a program counter it has already retired while no register value has moved since that earlier visit. This is treated as an endless loop.
- The reference has retired its full instruction allowance.
- The two sides have produced different register-value changes.

Register comparison happens only at synchronization points, and a synchronization point is a write that actually alters a register. Each side keeps a shadow copy of its own register file. Only writes that alter a non-zero register enter that side's in-order queue. Queue heads are compared pairwise as soon as both queues hold an entry. The loop test is deliberately conservative. Every retired reference PC is stored in a ring history together with a change epoch, and the epoch advances on each altering reference write. A loop is declared only on an exact match of both PC and epoch.

Top module: `lockstep_exec_ctrl`

## Requirements
- R1: A reference retire whose PC matches a history entry recorded in the current epoch sets `stop` at the next clock edge, with `stop_reason` = 1 (loop).
- R2: A reference write that changes a non-zero register advances the epoch. A PC revisited after such a write is not a loop. A third visit within the same epoch is a loop.
- R3: A write of the value a register already holds neither advances the epoch nor enters the comparison queue.
- R4: Writes to register index 0 are ignored on both sides. They cause no epoch step and no comparison.
- R5: The BUDGET-th reference retire (default 10000) sets `stop` with `stop_reason` = 2 (budget). A lower-priority event does not override this code.
- R6: Queued changes are compared in order, by register index and by value. A difference sets `stop` with `stop_reason` = 3 (mismatch), two edges after the later write of the pair.
- R7: Matching change streams do not stop the run, even when one side runs up to FIFO_DEPTH changes ahead of the other.
- R8: A change arriving for a queue that is full and not being drained this cycle is treated as a mismatch (code 3).
- R9: After reset, `stop` = 0 and `stop_reason` = 0. Once `stop` is set, it and `stop_reason` hold until reset, and all further inputs are ignored.
- R10: When several events occur on the same edge, the priority is mismatch (3), then loop (1), then budget (2).
- R11: The history holds the HIST_DEPTH (default 64) most recent reference PCs, and the oldest entry is overwritten first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_retire_vld | input | 1 | Reference model retired an instruction |
| ref_pc | input | XLEN | PC of the reference retire |
| ref_wr_en | input | 1 | Reference retire writes a register |
| ref_wr_idx | input | IDX_W | Reference destination register index |
| ref_wr_data | input | XLEN | Reference write value |
| cut_retire_vld | input | 1 | Core under test retired an instruction |
| cut_wr_en | input | 1 | Core retire writes a register |
| cut_wr_idx | input | IDX_W | Core destination register index |
| cut_wr_data | input | XLEN | Core write value |
| stop | output | 1 | Run must end (sticky) |
| stop_reason | output | 2 | 0 none, 1 loop, 2 budget, 3 mismatch |

## Verification
Every internal fault in this block eventually shows up on `stop`, either as a stop that comes too early or a stop that never comes.
- A corrupted shadow register or epoch either hides a loop or invents one. The effect appears one edge after the revisiting retire.
- A broken queue or comparator gives a spurious code 3, or a missing one, within two edges of the pair involved.
- An off-by-one in the allowance counter moves the budget stop by exactly one retire.

Directed sequences place the boundaries at known cycles. A seeded random stream of matching writes, including repeated values and index-0 writes, must never stop the run. A single corrupted pair must then give code 3.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  typedef enum logic [1:0] {
    RSN_NONE     = 2'd0,
    RSN_LOOP     = 2'd1,
    RSN_BUDGET   = 2'd2,
    RSN_MISMATCH = 2'd3
  } stop_rsn_e;

  // Priority: divergence first, then loop, then allowance exhausted.
  function automatic stop_rsn_e pick_reason(input logic loop_e, input logic budget_e,
                                            input logic mism_e);
    if (mism_e)        return RSN_MISMATCH;
    else if (loop_e)   return RSN_LOOP;
    else if (budget_e) return RSN_BUDGET;
    else               return RSN_NONE;
  endfunction

endpackage

// File: rtl/lsc_fifo.sv
module lsc_fifo #(
  parameter int W     = 37,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= ptr_next(wp);
      if (pop)  rp <= ptr_next(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R6
  AST_FIFO_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop); // R8
  AST_FIFO_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R7

endmodule

// File: rtl/lsc_change_tracker.sv
module lsc_change_tracker #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_vld,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  output logic             changed
);
  localparam int NREG = 1 << IDX_W;

  logic [XLEN-1:0] shadow [NREG];

  // A write counts only if it targets a non-zero index and alters the value.
  assign changed = wr_vld && (wr_idx != '0) && (shadow[wr_idx] != wr_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) shadow[i] <= '0;
    end else if (changed) begin
      shadow[wr_idx] <= wr_data;
    end
  end

  AST_X0_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    shadow[0] == '0); // R4

endmodule

// File: rtl/lsc_pc_history.sv
module lsc_pc_history #(
  parameter int XLEN    = 32,
  parameter int EPOCH_W = 16,
  parameter int DEPTH   = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               look_en,
  input  logic [XLEN-1:0]    pc,
  input  logic [EPOCH_W-1:0] epoch,
  output logic               hit
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic               ent_vld [DEPTH];
  logic [XLEN-1:0]    ent_pc  [DEPTH];
  logic [EPOCH_W-1:0] ent_ep  [DEPTH];
  logic [AW-1:0]      wptr;
  logic [DEPTH-1:0]   match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = ent_vld[g] && (ent_pc[g] == pc) && (ent_ep[g] == epoch);
  end

  assign hit = look_en && (match != '0);

  always_ff @(posedge clk) begin
    if (look_en) begin
      ent_pc[wptr] <= pc;
      ent_ep[wptr] <= epoch;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      for (int i = 0; i < DEPTH; i++) ent_vld[i] <= 1'b0;
    end else if (look_en) begin
      ent_vld[wptr] <= 1'b1;
      wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
    end
  end

  AST_HIST_WPTR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    !look_en |=> $stable(wptr)); // R11

endmodule

// File: rtl/lockstep_exec_ctrl.sv
module lockstep_exec_ctrl #(
  parameter int XLEN       = 32,
  parameter int IDX_W      = 5,
  parameter int HIST_DEPTH = 64,
  parameter int FIFO_DEPTH = 16,
  parameter int EPOCH_W    = 16,
  parameter int BUDGET     = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_retire_vld,
  input  logic [XLEN-1:0]  ref_pc,
  input  logic             ref_wr_en,
  input  logic [IDX_W-1:0] ref_wr_idx,
  input  logic [XLEN-1:0]  ref_wr_data,
  input  logic             cut_retire_vld,
  input  logic             cut_wr_en,
  input  logic [IDX_W-1:0] cut_wr_idx,
  input  logic [XLEN-1:0]  cut_wr_data,
  output logic             stop,
  output logic [1:0]       stop_reason
);
  import lsc_pkg::*;

  localparam int QW    = IDX_W + XLEN;
  localparam int CNT_W = $clog2(BUDGET + 1);

  logic               active, ref_ret;
  logic               ref_chg, cut_chg;
  logic [EPOCH_W-1:0] epoch;
  logic [CNT_W-1:0]   ret_cnt;
  logic               loop_evt, budget_evt, mism_evt, any_evt;
  logic               ref_push, cut_push, pair_pop, pair_diff, overflow;
  logic               ref_empty, cut_empty, ref_full, cut_full;
  logic [QW-1:0]      ref_head, cut_head;
  stop_rsn_e          reason_q;

  assign active  = !stop;
  assign ref_ret = ref_retire_vld && active;

  lsc_change_tracker #(.XLEN(XLEN), .IDX_W(IDX_W)) u_ref_trk (
    .clk(clk), .rst_n(rst_n), .wr_vld(ref_ret && ref_wr_en),
    .wr_idx(ref_wr_idx), .wr_data(ref_wr_data), .changed(ref_chg));

  lsc_change_tracker #(.XLEN(XLEN), .IDX_W(IDX_W)) u_cut_trk (
    .clk(clk), .rst_n(rst_n), .wr_vld(cut_retire_vld && cut_wr_en && active),
    .wr_idx(cut_wr_idx), .wr_data(cut_wr_data), .changed(cut_chg));

  // Loop detection: the lookup uses the epoch before this retire's own write.
  lsc_pc_history #(.XLEN(XLEN), .EPOCH_W(EPOCH_W), .DEPTH(HIST_DEPTH)) u_hist (
    .clk(clk), .rst_n(rst_n), .look_en(ref_ret), .pc(ref_pc),
    .epoch(epoch), .hit(loop_evt));

  always_ff @(posedge clk) begin
    if (!rst_n)       epoch <= '0;
    else if (ref_chg) epoch <= epoch + 1'b1;
  end

  // Instruction allowance on the reference side.
  assign budget_evt = ref_ret && (ret_cnt == CNT_W'(BUDGET - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)       ret_cnt <= '0;
    else if (ref_ret) ret_cnt <= ret_cnt + 1'b1;
  end

  // In-order comparison of value-changing writes.
  assign pair_pop  = active && !ref_empty && !cut_empty;
  assign pair_diff = pair_pop && (ref_head != cut_head);
  assign overflow  = (ref_chg && ref_full && !pair_pop) ||
                     (cut_chg && cut_full && !pair_pop);
  assign ref_push  = ref_chg && (!ref_full || pair_pop);
  assign cut_push  = cut_chg && (!cut_full || pair_pop);
  assign mism_evt  = pair_diff || overflow;

  lsc_fifo #(.W(QW), .DEPTH(FIFO_DEPTH)) u_ref_q (
    .clk(clk), .rst_n(rst_n), .push(ref_push), .din({ref_wr_idx, ref_wr_data}),
    .pop(pair_pop), .dout(ref_head), .empty(ref_empty), .full(ref_full));

  lsc_fifo #(.W(QW), .DEPTH(FIFO_DEPTH)) u_cut_q (
    .clk(clk), .rst_n(rst_n), .push(cut_push), .din({cut_wr_idx, cut_wr_data}),
    .pop(pair_pop), .dout(cut_head), .empty(cut_empty), .full(cut_full));

  // Sticky stop decision.
  assign any_evt = loop_evt || budget_evt || mism_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop     <= 1'b0;
      reason_q <= RSN_NONE;
    end else if (active && any_evt) begin
      stop     <= 1'b1;
      reason_q <= pick_reason(loop_evt, budget_evt, mism_evt);
    end
  end

  assign stop_reason = reason_q;

  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (stop && $stable(stop_reason))); // R9
  AST_REASON_TRACKS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop == (stop_reason != 2'd0)); // R9
  AST_EPOCH_FROZEN_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> $stable(epoch)); // R9
  AST_EPOCH_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (epoch != $past(epoch)) |-> (epoch == EPOCH_W'($past(epoch) + 1'b1))); // R2
  AST_BUDGET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ret_cnt <= CNT_W'(BUDGET)); // R5

endmodule

// File: tb/tb_lockstep_exec_ctrl.sv
module tb_lockstep_exec_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        r_vld = 0, r_we = 0, c_vld = 0, c_we = 0;
  logic [31:0] r_pc = 0, r_dat = 0, c_dat = 0;
  logic [4:0]  r_idx = 0, c_idx = 0;
  logic        stop, stop_b;
  logic [1:0]  reason, reason_b;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] sh [32];

  always #4 clk = ~clk;

  lockstep_exec_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ref_retire_vld(r_vld), .ref_pc(r_pc), .ref_wr_en(r_we),
    .ref_wr_idx(r_idx), .ref_wr_data(r_dat), .cut_retire_vld(c_vld), .cut_wr_en(c_we),
    .cut_wr_idx(c_idx), .cut_wr_data(c_dat), .stop(stop), .stop_reason(reason));

  lockstep_exec_ctrl #(.BUDGET(3)) dut_b (
    .clk(clk), .rst_n(rst_n), .ref_retire_vld(r_vld), .ref_pc(r_pc), .ref_wr_en(r_we),
    .ref_wr_idx(r_idx), .ref_wr_data(r_dat), .cut_retire_vld(c_vld), .cut_wr_en(c_we),
    .cut_wr_idx(c_idx), .cut_wr_data(c_dat), .stop(stop_b), .stop_reason(reason_b));

  function automatic logic [1:0] exp_reason(input logic lp, input logic bg, input logic mm);
    return mm ? 2'd3 : (lp ? 2'd1 : (bg ? 2'd2 : 2'd0));
  endfunction

  function automatic logic alters(input logic [4:0] idx, input logic [31:0] oldv,
                                  input logic [31:0] newv);
    return (idx != 0) && (oldv != newv);
  endfunction

  task automatic step(input logic rv, input logic [31:0] rpc, input logic rwe,
                      input logic [4:0] ridx, input logic [31:0] rdat, input logic cv,
                      input logic cwe, input logic [4:0] cidx, input logic [31:0] cdat);
    @(negedge clk);
    r_vld = rv; r_pc = rpc; r_we = rwe; r_idx = ridx; r_dat = rdat;
    c_vld = cv; c_we = cwe; c_idx = cidx; c_dat = cdat;
  endtask

  task automatic idle(input int n);
    repeat (n) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic both(input logic [31:0] pc, input logic [4:0] idx, input logic [31:0] v);
    step(1, pc, 1, idx, v, 1, 1, idx, v);
  endtask

  task automatic chk(input string tag, input logic s_act, input logic [1:0] r_act,
                     input logic s_exp, input logic [1:0] r_exp);
    n_chk++;
    if (s_act !== s_exp || r_act !== r_exp) begin
      n_fail++;
      $display("FAIL %s: stop=%0b reason=%0d expected stop=%0b reason=%0d",
               tag, s_act, r_act, s_exp, r_exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    idle(3);
    rst_n = 1;
    for (int i = 0; i < 32; i++) sh[i] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: stop=%0b reason=%0d expected run to finish", stop, reason);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    idle(1);
    chk("R9 reset state", stop, reason, 0, 2'd0);

    // R1: plain revisit without register change
    step(1, 32'h100, 0, 0, 0, 0, 0, 0, 0);
    step(1, 32'h104, 0, 0, 0, 0, 0, 0, 0);
    idle(1);
    chk("R1 no loop before revisit", stop, reason, 0, 2'd0);
    step(1, 32'h100, 0, 0, 0, 0, 0, 0, 0);
    idle(1);
    chk("R1 loop on revisit", stop, reason, 1, 2'd1);
    // R9: stimulus after stop ignored
    both(32'h900, 5'd3, 32'h1);
    both(32'h904, 5'd3, 32'h2);
    step(1, 32'h908, 1, 5'd4, 32'h5, 1, 1, 5'd4, 32'h6);
    idle(3);
    chk("R9 sticky after further input", stop, reason, 1, 2'd1);

    // R2: value change separates visits
    do_reset();
    both(32'h200, 5'd5, 32'h7);
    step(1, 32'h200, 0, 0, 0, 0, 0, 0, 0);
    idle(3);
    chk("R2 revisit after change is no loop", stop, reason, 0, 2'd0);
    step(1, 32'h200, 0, 0, 0, 0, 0, 0, 0);
    idle(1);
    chk("R2 third visit same epoch loops", stop, reason, 1, 2'd1);

    // R3: unchanged-value writes: no epoch step, no comparison
    do_reset();
    both(32'h300, 5'd5, 32'h7);
    step(1, 32'h304, 1, 5'd5, 32'h7, 0, 0, 0, 0);
    both(32'h308, 5'd6, 32'h3);
    idle(3);
    chk("R3 repeated value not compared", stop, reason, 0, 2'd0);
    step(1, 32'h304, 0, 0, 0, 0, 0, 0, 0);
    idle(3);
    chk("R3 epoch advanced by real change only", stop, reason, 0, 2'd0);
    step(1, 32'h30c, 1, 5'd6, 32'h3, 0, 0, 0, 0);
    step(1, 32'h30c, 0, 0, 0, 0, 0, 0, 0);
    idle(1);
    chk("R3 repeated value keeps epoch", stop, reason, 1, 2'd1);

    // R4: index 0 ignored on both sides
    do_reset();
    step(1, 32'h400, 1, 5'd0, 32'h5, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1, 5'd0, 32'h9);
    idle(3);
    chk("R4 x0 writes not compared", stop, reason, 0, 2'd0);
    step(1, 32'h400, 0, 0, 0, 0, 0, 0, 0);
    idle(1);
    chk("R4 x0 write keeps epoch", stop, reason, 1, 2'd1);

    // R6: index difference
    do_reset();
    step(1, 32'h600, 1, 5'd3, 32'h5, 1, 1, 5'd4, 32'h5);
    idle(1);
    chk("R6 no stop one edge after pair", stop, reason, 0, 2'd0);
    idle(1);
    chk("R6 index mismatch", stop, reason, 1, 2'd3);

    // R7: skewed but matching streams
    do_reset();
    for (int i = 0; i < 10; i++)
      step(1, 32'h700 + 4 * i, 1, 5'(i + 1), 32'h50 + i, 0, 0, 0, 0);
    for (int i = 0; i < 10; i++)
      step(0, 0, 0, 0, 0, 1, 1, 5'(i + 1), 32'h50 + i);
    idle(3);
    chk("R7 skewed matching streams", stop, reason, 0, 2'd0);
    step(0, 0, 0, 0, 0, 1, 1, 5'd2, 32'hdead);
    step(1, 32'h7f0, 1, 5'd2, 32'hbeef, 0, 0, 0, 0);
    idle(3);
    chk("R6 value mismatch after skew", stop, reason, 1, 2'd3);

    // R8 + R10: overflow and loop on same edge -> mismatch wins
    do_reset();
    step(1, 32'h800, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 1; i <= 16; i++) step(0, 0, 0, 0, 0, 1, 1, 5'(i), 32'(i));
    idle(2);
    chk("R8 full queue alone is no stop", stop, reason, 0, 2'd0);
    step(1, 32'h800, 0, 0, 0, 1, 1, 5'd17, 32'd17);
    idle(1);
    chk("R10 overflow beats loop", stop, reason, 1, exp_reason(1, 0, 1));

    // R5 + R10 on the small-budget instance
    do_reset();
    step(1, 32'hA00, 0, 0, 0, 0, 0, 0, 0);
    step(1, 32'hA04, 0, 0, 0, 0, 0, 0, 0);
    idle(1);
    chk("R5 small budget not yet spent", stop_b, reason_b, 0, 2'd0);
    step(1, 32'hA08, 0, 0, 0, 0, 0, 0, 0);
    idle(1);
    chk("R5 small budget spent", stop_b, reason_b, 1, 2'd2);
    do_reset();
    step(1, 32'hB00, 0, 0, 0, 0, 0, 0, 0);
    step(1, 32'hB04, 0, 0, 0, 0, 0, 0, 0);
    step(1, 32'hB00, 0, 0, 0, 0, 0, 0, 0);
    idle(1);
    chk("R10 loop beats budget", stop_b, reason_b, 1, exp_reason(1, 1, 0));

    // R11: history depth
    do_reset();
    for (int i = 0; i <= 64; i++) step(1, 32'h1000 + 4 * i, 0, 0, 0, 0, 0, 0, 0);
    step(1, 32'h1000, 0, 0, 0, 0, 0, 0, 0);
    idle(1);
    chk("R11 evicted PC not a loop", stop, reason, 0, 2'd0);
    step(1, 32'h1000 + 4 * 64, 0, 0, 0, 0, 0, 0, 0);
    idle(1);
    chk("R11 retained PC loops", stop, reason, 1, 2'd1);

    // R5: full default allowance
    do_reset();
    for (int i = 0; i < 9999; i++) step(1, 32'h40000 + 4 * i, 0, 0, 0, 0, 0, 0, 0);
    idle(1);
    chk("R5 one retire before budget", stop, reason, 0, 2'd0);
    step(1, 32'h80000, 0, 0, 0, 0, 0, 0, 0);
    idle(1);
    chk("R5 budget reached", stop, reason, 1, 2'd2);

    // R7/R3/R4 random matching stream, then R6 injected divergence
    do_reset();
    for (int k = 0; k < 400; k++) begin
      logic [4:0]  ix;
      logic [31:0] v;
      ix = ($urandom % 5 == 0) ? 5'd0 : 5'($urandom % 32);
      v  = ($urandom % 10 < 3) ? sh[ix] : $urandom;
      if ($urandom % 5 == 0) idle(1);
      else if ($urandom % 10 < 3) step(1, 32'h20000 + 4 * k, 0, 0, 0, 1, 0, 0, 0);
      else begin
        both(32'h20000 + 4 * k, ix, v);
        if (alters(ix, sh[ix], v)) sh[ix] = v;
      end
      if (k % 100 == 99) begin
        idle(3);
        chk("R7 random matching stream", stop, reason, 0, 2'd0);
      end
    end
    for (int k = 0; k < 100; k++) begin
      logic [4:0]  ix;
      logic [31:0] v, w;
      ix = 5'(1 + $urandom % 31);
      v  = $urandom;
      if (alters(ix, sh[ix], v)) begin
        w = ((v ^ 32'd1) != sh[ix]) ? (v ^ 32'd1) : (v ^ 32'd2);
        step(1, 32'h30000, 1, ix, v, 1, 1, ix, w);
        break;
      end
    end
    idle(3);
    chk("R6 injected random divergence", stop, reason, 1, 2'd3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule